// File: doc/BRIEF.md
# Byte-Wide Flash Bus Control Unit

This block models the control side of a byte-wide flash memory as seen from its pins. It decodes four active-low controls (chip select, output enable, write strobe and a combined reset/power-down pin), decides when the 8-bit data port is driven, and runs a small command interpreter. The interpreter picks what a read returns: array data, one of two identifier bytes, or a status byte. Two-write command sequences start an erase, program or lock-bit operation. Each operation is modelled as a programmable number of clock cycles, and a ready output is low for that time.

The power-down pin acts as an asynchronous reset. Pulling it low stops any running operation, floats the data port and holds ready low. After the pin returns high, the block waits a programmable number of wake-up cycles. It then comes back in array-read mode with a status byte of 80H. A single program-voltage-good input replaces the analog supply checks. Array contents come in on a separate input, so no cell storage is modelled.

Top module: `flash_bus_ctrl`

## Requirements
- R1: While `oe_n` is high, `dq_oe` is 0.
- R2: While `ce_n` is high, `dq_oe` is 0 whatever `oe_n` and `we_n` do.
- R3: With `pd_n` high and the wake-up interval over, `dq_oe` is 1 exactly when `ce_n` and `oe_n` are low and `we_n` is high.
- R4: While `pd_n` is low, `dq_oe` and `rdy` are 0 and any running operation is abandoned. After `pd_n` rises, `rdy` stays 0 and writes are ignored for WAKE_CYC clock cycles. The unit then reads in array mode and its status byte is 80H.
- R5: A command is taken on the clock after `we_n` rises while `ce_n` is low. The command byte on `din` has these effects: FFH selects array reads (`arr_q`), 90H selects identifier reads (MFR_ID when `addr0`=0, DEV_ID when `addr0`=1), 70H selects status reads, and 50H clears the error bit without changing the read mode.
- R6: The status byte holds ready in bit 7 (1 = ready), the error flag in bit 3, and zeros in all other bits.
- R7: The sequence 20H then D0H starts an erase. `rdy` is 0 for ERASE_CYC cycles and the read mode becomes status.
- R8: The sequence 40H then any byte starts a program of PROG_CYC cycles. The sequence 60H then 01H starts a lock-bit operation of LOCK_CYC cycles.
- R9: After 20H or 60H, a second byte other than the one the sequence needs starts no operation and returns the unit to array reads.
- R10: If `vpp_ok` is 0 when the second write of a sequence is taken, no operation starts, the error bit is set, and the read mode becomes status (status byte 88H).
- R11: Raising `ce_n` while an operation runs does not shorten it.
- R12: Writes taken while an operation runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pd_n | input | 1 | Active-low reset/power-down, asynchronous |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| vpp_ok | input | 1 | Program voltage is above lockout |
| addr0 | input | 1 | Selects the identifier byte |
| din | input | 8 | Command or data byte being written |
| arr_q | input | 8 | Byte supplied by the array for array reads |
| dq_out | output | 8 | Byte presented on the data port |
| dq_oe | output | 1 | Tri-state enable for the data port |
| rdy | output | 1 | 1 when ready, 0 when busy, powered down or waking |

## Verification
The hardest case to reach from the ports is an abort. The power-down pin has to fall in the middle of an erase, and the unit must then come back through its wake-up interval into array mode with status 80H. The stimulus starts an erase, waits a few cycles, and pulls the pin low. While the pin is released and the unit is still waking, the stimulus writes an identifier command at once; a later read must still return array data. A second hard case is an operation that ends while the chip is deselected. Timing is checked by counting the low cycles of `rdy` while `ce_n` is held high, and by writing commands during the busy period.

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl #(
  parameter int WAKE_CYC  = 4,
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 5,
  parameter int LOCK_CYC  = 8,
  parameter int CW        = 8,
  parameter logic [7:0] MFR_ID = 8'hA7,
  parameter logic [7:0] DEV_ID = 8'h4E
) (
  input  logic       clk,
  input  logic       pd_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       vpp_ok,
  input  logic       addr0,
  input  logic [7:0] din,
  input  logic [7:0] arr_q,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic       rdy
);
  localparam logic [1:0] M_ARR = 2'd0, M_ID = 2'd1, M_SR = 2'd2;
  localparam logic [1:0] P_NONE = 2'd0, P_ERS = 2'd1, P_PRG = 2'd2, P_LCK = 2'd3;

  logic [1:0]    mode, pend;
  logic          busy, err, we_q;
  logic [CW-1:0] wcnt, ocnt, dur;
  logic          awake, wr, go;

  assign awake = (wcnt == '0);
  assign wr    = we_n & ~we_q & ~ce_n & awake & ~busy;
  assign go    = (pend == P_PRG) | ((pend == P_ERS) & (din == 8'hD0)) |
                 ((pend == P_LCK) & (din == 8'h01));
  assign dur   = (pend == P_ERS) ? CW'(ERASE_CYC - 1) :
                 (pend == P_PRG) ? CW'(PROG_CYC - 1) : CW'(LOCK_CYC - 1);

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) begin
      mode <= M_ARR;
      pend <= P_NONE;
      busy <= 1'b0;
      err  <= 1'b0;
      we_q <= 1'b1;
      wcnt <= CW'(WAKE_CYC);
      ocnt <= '0;
    end else begin
      we_q <= we_n;
      if (!awake) wcnt <= wcnt - 1'b1;
      if (busy) begin
        if (ocnt == '0) busy <= 1'b0;
        else            ocnt <= ocnt - 1'b1;
      end
      if (wr) begin
        if (pend != P_NONE) begin
          pend <= P_NONE;
          if (go) begin
            mode <= M_SR;
            if (vpp_ok) begin
              busy <= 1'b1;
              ocnt <= dur;
            end else begin
              err <= 1'b1;
            end
          end else begin
            mode <= M_ARR;
          end
        end else begin
          case (din)
            8'hFF: mode <= M_ARR;
            8'h90: mode <= M_ID;
            8'h70: mode <= M_SR;
            8'h50: err  <= 1'b0;
            8'h20: begin pend <= P_ERS; mode <= M_SR; end
            8'h40: begin pend <= P_PRG; mode <= M_SR; end
            8'h60: begin pend <= P_LCK; mode <= M_SR; end
            default: ;
          endcase
        end
      end
    end
  end

  assign dq_oe  = pd_n & awake & ~ce_n & ~oe_n & we_n;
  assign rdy    = pd_n & awake & ~busy;
  assign dq_out = (mode == M_ID) ? (addr0 ? DEV_ID : MFR_ID) :
                  (mode == M_SR) ? {~busy, 3'b000, err, 3'b000} : arr_q;
endmodule

// File: rtl/flash_bus_ctrl_chk.sv
module flash_bus_ctrl_chk (
  input logic       clk,
  input logic       pd_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       vpp_ok,
  input logic       dq_oe,
  input logic       rdy,
  input logic [7:0] dq_out,
  input logic [1:0] mode
);
  always_comb begin
    if (pd_n === 1'b0) begin
      assert_pd_quiet_R4: assert (!dq_oe && !rdy);
    end
  end

  assert_oe_hiz_R1: assert property (@(posedge clk) disable iff (!pd_n)
    oe_n |-> !dq_oe);

  assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!pd_n)
    ce_n |-> !dq_oe);

  assert_vpp_gate_R10: assert property (@(posedge clk) disable iff (!pd_n)
    $fell(rdy) |-> $past(vpp_ok));

  assert_busy_bit_R6: assert property (@(posedge clk) disable iff (!pd_n)
    (dq_oe && mode == 2'd2 && !rdy) |-> (dq_out[7] == 1'b0));

  assert_ready_bit_R6: assert property (@(posedge clk) disable iff (!pd_n)
    (dq_oe && mode == 2'd2 && rdy) |-> (dq_out[7] == 1'b1));
endmodule

bind flash_bus_ctrl flash_bus_ctrl_chk chk_i (
  .clk(clk), .pd_n(pd_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_ok(vpp_ok),
  .dq_oe(dq_oe), .rdy(rdy), .dq_out(dq_out), .mode(mode)
);

// File: tb/flash_bus_ctrl_test.sv
module flash_bus_ctrl_test;
  localparam int WAKE = 4, ERS = 12, PRG = 5, LCK = 8;
  localparam logic [7:0] MFR = 8'hA7, DEV = 8'h4E;

  logic clk = 0, pd_n = 0, ce_n = 1, oe_n = 1, we_n = 1, vpp_ok = 1, addr0 = 0;
  logic [7:0] din = 0, arr_q = 8'h3C, dq_out;
  logic dq_oe, rdy;
  int total = 0, bad = 0;
  logic [7:0] rv;
  logic roe;
  int n;

  always #5 clk = ~clk;

  flash_bus_ctrl #(.WAKE_CYC(WAKE), .ERASE_CYC(ERS), .PROG_CYC(PRG), .LOCK_CYC(LCK),
                   .MFR_ID(MFR), .DEV_ID(DEV)) uut (
    .clk(clk), .pd_n(pd_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .vpp_ok(vpp_ok),
    .addr0(addr0), .din(din), .arr_q(arr_q), .dq_out(dq_out), .dq_oe(dq_oe), .rdy(rdy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); ce_n = 0; we_n = 0; din = b;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); addr0 = a; ce_n = 0; oe_n = 0;
    #1 rv = dq_out; roe = dq_oe;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic count_low();
    n = 0;
    while (!rdy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string req);
    rd(a);
    chk(roe == 1'b1, req, roe, 1);
    chk(rv == exp, req, rv, exp);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk(dq_oe == 0, "R4 reset oe", dq_oe, 0);
    chk(rdy == 0, "R4 reset rdy", rdy, 0);
    @(negedge clk); @(negedge clk);
    pd_n = 1;
    count_low();
    chk(n == WAKE, "R4 wake cycles", n, WAKE);
    rd_chk(0, 8'h3C, "R4 array after wake");
    wr(8'h70);
    rd_chk(0, 8'h80, "R4 R6 status 80H");

    din = 8'hFF;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); ce_n = c[0]; oe_n = c[1]; we_n = c[2];
      #1;
      chk(dq_oe == (!c[0] && !c[1] && c[2]), "R1 R2 R3 pin decode", dq_oe,
          (!c[0] && !c[1] && c[2]));
    end
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;

    wr(8'h90);
    rd_chk(0, MFR, "R5 manufacturer id");
    rd_chk(1, DEV, "R5 device id");
    wr(8'hFF);
    for (int v = 0; v < 256; v += 37) begin
      arr_q = 8'(v);
      rd_chk(0, 8'(v), "R5 array read");
    end
    arr_q = 8'h3C;

    wr(8'h20); wr(8'hD0);
    count_low();
    chk(n == ERS, "R7 R11 erase cycles", n, ERS);
    rd_chk(0, 8'h80, "R7 status after erase");

    wr(8'h40); wr(8'h5A);
    count_low();
    chk(n == PRG, "R8 program cycles", n, PRG);
    wr(8'h60); wr(8'h01);
    count_low();
    chk(n == LCK, "R8 lock cycles", n, LCK);

    wr(8'h20); wr(8'h33);
    chk(rdy == 1, "R9 bad erase confirm", rdy, 1);
    rd_chk(0, 8'h3C, "R9 array after bad confirm");
    wr(8'h60); wr(8'hFF);
    chk(rdy == 1, "R9 bad lock confirm", rdy, 1);
    rd_chk(0, 8'h3C, "R9 array after bad lock");

    vpp_ok = 0;
    wr(8'h40); wr(8'h11);
    chk(rdy == 1, "R10 no op at low vpp", rdy, 1);
    rd_chk(0, 8'h88, "R10 error bit");
    wr(8'h50);
    rd_chk(0, 8'h80, "R5 clear error");
    vpp_ok = 1;

    wr(8'h20); wr(8'hD0);
    rd_chk(0, 8'h00, "R6 busy status");
    wr(8'hFF); wr(8'h90);
    count_low();
    rd_chk(0, 8'h80, "R12 writes ignored while busy");

    wr(8'h20); wr(8'hD0);
    @(negedge clk); @(negedge clk);
    pd_n = 0; ce_n = 0; oe_n = 0;
    #1;
    chk(dq_oe == 0, "R4 pd hiz", dq_oe, 0);
    chk(rdy == 0, "R4 pd rdy", rdy, 0);
    @(negedge clk); ce_n = 1; oe_n = 1;
    pd_n = 1;
    wr(8'h90);
    count_low();
    rd_chk(0, 8'h3C, "R4 abort to array, wake write ignored");
    wr(8'h70);
    rd_chk(0, 8'h80, "R4 status 80H after abort");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule